// File: doc/BRIEF.md
# Round-Robin Shared Pin Arbiter

This block lets several off-chip device controllers share one set of pin-side bus signals. Each controller has a request line and receives a grant line. A small state machine picks one owner at a time in rotating order. The owner's address, read strobe, write strobe, write data and write-data output enable are steered onto the shared pin signals. Read data coming back from the pins is copied to every controller. Each controller's chip select is not shared and goes straight to its own pin.

The handshake depends on the grant state. While a controller's grant is low, a high request asks for the bus in the current cycle. The grant is registered, so it appears one cycle later. While the grant is high, a high request asks for the next cycle as well. An owner therefore lowers its request in the last cycle it needs. It still holds the grant in that cycle and loses it on the following edge.

The state machine has two states. `ST_IDLE` means no controller owns the bus. `ST_OWNED` means exactly one grant is high. The transitions are:
- idle-to-owned when any request is seen in `ST_IDLE`.
- hold when the owner keeps its request high.
- handover when the owner drops its request while another controller is requesting. The state stays `ST_OWNED` and the grant moves to that controller.
- release when the owner drops its request and nobody else is requesting. The state returns to `ST_IDLE`.

Each interface has its own address and data width, both parameters. A narrower interface is aligned at bit 0, and the pin bits above its width read as zero.

Top module: `rrps_pin_sharer`

## Requirements
- R1: A new grant goes to the first requesting controller found by searching upward from the controller after the one most recently granted, wrapping from the last index to 0. The search pointer is 0 after reset and moves only when a new grant is issued.
- R2: When no grant is active and a request is high in cycle t, the chosen controller's grant is high in cycle t+1 and not in cycle t.
- R3: While the owner keeps its request high, its grant stays high, even if other controllers are requesting.
- R4: If the owner's request is low in cycle k, its grant is still high in cycle k and low in cycle k+1. If other requests are high in cycle k, the controller chosen by R1 holds the grant in cycle k+1.
- R5: At most one grant is high in any cycle.
- R6: When no grant is active and no request is high, no grant is issued.
- R7: A controller that requests again in the cycle after its release gets the grant back one cycle later if it is the only requester. It keeps the grant for as long as it holds its request.
- R8: While controller i owns the bus, the pin address equals its address with bits at and above its own address width forced to 0. The pin write data equals its write data with bits at and above its own data width forced to 0. The pin read strobe, write strobe and write-data output enable equal controller i's values.
- R9: While no grant is active, the pin address, write data, read strobe and write strobe are 0, and the write-data output enable is off.
- R10: Each controller's chip select appears on its own chip-select pin in the same cycle, whatever the grant state.
- R11: The pin read data appears unchanged, in the same cycle, on every controller's read-data port.
- R12: While reset is asserted, all grants are low and the write-data output enable is off, whatever the request and enable inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_req | input | NUM_IF | Request, one bit per controller |
| ctl_grant | output | NUM_IF | Grant, one bit per controller |
| ctl_addr | input | NUM_IF*ADDR_W | Addresses; controller i uses slice i |
| ctl_rd | input | NUM_IF | Read strobes |
| ctl_wr | input | NUM_IF | Write strobes |
| ctl_wdata | input | NUM_IF*DATA_W | Write data; controller i uses slice i |
| ctl_wdata_oe | input | NUM_IF | Write-data output enables |
| ctl_rdata | output | NUM_IF*DATA_W | Read data copied to each controller |
| ctl_cs | input | NUM_IF | Chip selects (not shared) |
| pin_addr | output | ADDR_W | Shared address pins |
| pin_rd | output | 1 | Shared read strobe pin |
| pin_wr | output | 1 | Shared write strobe pin |
| pin_wdata | output | DATA_W | Shared write-data pins |
| pin_wdata_oe | output | 1 | Shared write-data output enable |
| pin_rdata | input | DATA_W | Read data from the pins |
| pin_cs | output | NUM_IF | One chip-select pin per controller |

## Verification
Two functions can fall in the same cycle: the release of the current owner and the grant to the next controller.

The directed sequence provokes this case. Controller 1 owns the bus, then drops its request while controllers 0 and 2 are both requesting. The bench then checks two cycles:
- In the drop cycle, controller 1 must still hold the grant.
- In the next cycle, the grant must have passed to controller 2, which follows 1 in rotation, with no idle cycle between the two owners.

The random phase repeats this overlap many times. Its expected grants come from a bench model of R1 to R4.

// File: rtl/rrps_pkg.sv
package rrps_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_OWNED = 1'b1
    } arb_state_t;

endpackage

// File: rtl/rrps_arbiter.sv
module rrps_arbiter
    import rrps_pkg::*;
#(
    parameter int NUM_IF = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IF-1:0] req,
    output logic [NUM_IF-1:0] grant
);

    localparam int IDX_W = (NUM_IF > 1) ? $clog2(NUM_IF) : 1;

    arb_state_t        state_q, state_d;
    logic [NUM_IF-1:0] grant_q, grant_d;
    logic [IDX_W-1:0]  ptr_q, ptr_d;
    logic [IDX_W-1:0]  win_idx, win_after;
    logic [NUM_IF-1:0] win_onehot;
    logic              win_found;
    logic              owner_keeps;

    // rotating search starting at the pointer
    always_comb begin
        int cand;
        win_found = 1'b0;
        win_idx   = '0;
        for (int k = 0; k < NUM_IF; k++) begin
            cand = int'(ptr_q) + k;
            if (cand >= NUM_IF) cand = cand - NUM_IF;
            if (!win_found && req[cand]) begin
                win_found = 1'b1;
                win_idx   = IDX_W'(cand);
            end
        end
        for (int k = 0; k < NUM_IF; k++) begin
            win_onehot[k] = win_found && (win_idx == IDX_W'(k));
        end
        win_after = (win_idx == IDX_W'(NUM_IF - 1)) ? '0 : win_idx + IDX_W'(1);
    end

    assign owner_keeps = |(grant_q & req);

    // next-state and output decisions
    always_comb begin
        state_d = state_q;
        grant_d = grant_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            ST_IDLE: begin
                if (win_found) begin
                    state_d = ST_OWNED;
                    grant_d = win_onehot;
                    ptr_d   = win_after;
                end
            end
            ST_OWNED: begin
                if (!owner_keeps) begin
                    if (win_found) begin
                        grant_d = win_onehot;
                        ptr_d   = win_after;
                    end else begin
                        state_d = ST_IDLE;
                        grant_d = '0;
                    end
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            grant_q <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            grant_q <= grant_d;
            ptr_q   <= ptr_d;
        end
    end

    assign grant = grant_q;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_q)); // R5

    AST_NO_DEFAULT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_q == '0 && req == '0) |=> (grant_q == '0)); // R6

    AST_OWNER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(grant_q & req)) |=> (grant_q == $past(grant_q))); // R3

    AST_OWNER_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_q != '0) && !(|(grant_q & req))) |=> ((grant_q & $past(grant_q)) == '0)); // R4

endmodule

// File: rtl/rrps_lane_mux.sv
module rrps_lane_mux #(
    parameter int          NUM_IF = 3,
    parameter int          W      = 16,
    parameter int unsigned LANE_W [NUM_IF] = '{16, 8, 12}
) (
    input  logic [NUM_IF-1:0]   sel,
    input  logic [NUM_IF*W-1:0] din,
    output logic [W-1:0]        dout
);

    logic [W-1:0] term [NUM_IF];

    for (genvar g = 0; g < NUM_IF; g++) begin : g_lane
        localparam int EFF = (int'(LANE_W[g]) >= W) ? W : int'(LANE_W[g]);
        localparam logic [W-1:0] MASK = {W{1'b1}} >> (W - EFF);

        assign term[g] = sel[g] ? (din[g*W +: W] & MASK) : '0;

        if (EFF < W) begin : g_chk
            always_comb begin
                if (sel[g] == 1'b1 && $onehot(sel)) begin
                    AST_UPPER_ZERO: assert ((dout >> EFF) == '0); // R8
                end
            end
        end
    end

    always_comb begin
        dout = '0;
        for (int i = 0; i < NUM_IF; i++) begin
            dout = dout | term[i];
        end
    end

endmodule

// File: rtl/rrps_pin_sharer.sv
module rrps_pin_sharer #(
    parameter int          NUM_IF = 3,
    parameter int          ADDR_W = 12,
    parameter int          DATA_W = 16,
    parameter int unsigned IF_AW [NUM_IF] = '{12, 8, 10},
    parameter int unsigned IF_DW [NUM_IF] = '{16, 8, 16}
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_IF-1:0]        ctl_req,
    output logic [NUM_IF-1:0]        ctl_grant,
    input  logic [NUM_IF*ADDR_W-1:0] ctl_addr,
    input  logic [NUM_IF-1:0]        ctl_rd,
    input  logic [NUM_IF-1:0]        ctl_wr,
    input  logic [NUM_IF*DATA_W-1:0] ctl_wdata,
    input  logic [NUM_IF-1:0]        ctl_wdata_oe,
    output logic [NUM_IF*DATA_W-1:0] ctl_rdata,
    input  logic [NUM_IF-1:0]        ctl_cs,
    output logic [ADDR_W-1:0]        pin_addr,
    output logic                     pin_rd,
    output logic                     pin_wr,
    output logic [DATA_W-1:0]        pin_wdata,
    output logic                     pin_wdata_oe,
    input  logic [DATA_W-1:0]        pin_rdata,
    output logic [NUM_IF-1:0]        pin_cs
);

    logic [NUM_IF-1:0] grant;

    rrps_arbiter #(.NUM_IF(NUM_IF)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (ctl_req),
        .grant (grant)
    );

    rrps_lane_mux #(.NUM_IF(NUM_IF), .W(ADDR_W), .LANE_W(IF_AW)) u_addr_mux (
        .sel  (grant),
        .din  (ctl_addr),
        .dout (pin_addr)
    );

    rrps_lane_mux #(.NUM_IF(NUM_IF), .W(DATA_W), .LANE_W(IF_DW)) u_wdata_mux (
        .sel  (grant),
        .din  (ctl_wdata),
        .dout (pin_wdata)
    );

    assign ctl_grant    = grant;
    assign pin_rd       = |(grant & ctl_rd);
    assign pin_wr       = |(grant & ctl_wr);
    assign pin_wdata_oe = rst_n & (|(grant & ctl_wdata_oe));
    assign pin_cs       = ctl_cs;

    for (genvar g = 0; g < NUM_IF; g++) begin : g_fan
        assign ctl_rdata[g*DATA_W +: DATA_W] = pin_rdata;
    end

    AST_OE_IN_RESET: assert property (@(posedge clk)
        !rst_n |-> (!pin_wdata_oe && ctl_grant == '0)); // R12

endmodule

// File: tb/rrps_pin_sharer_bench.sv
`timescale 1ns/1ps
module rrps_pin_sharer_bench;

    localparam int N      = 3;
    localparam int AW     = 12;
    localparam int DW     = 16;
    localparam int TOT_AW = N * AW;
    localparam int TOT_DW = N * DW;
    localparam int BAW [N] = '{12, 8, 10};
    localparam int BDW [N] = '{16, 8, 16};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      ctl_req = '0;
    logic [N-1:0]      ctl_grant;
    logic [TOT_AW-1:0] ctl_addr = '0;
    logic [N-1:0]      ctl_rd = '0, ctl_wr = '0, ctl_wdata_oe = '0, ctl_cs = '0;
    logic [TOT_DW-1:0] ctl_wdata = '0;
    logic [TOT_DW-1:0] ctl_rdata;
    logic [AW-1:0]     pin_addr;
    logic              pin_rd, pin_wr, pin_wdata_oe;
    logic [DW-1:0]     pin_wdata;
    logic [DW-1:0]     pin_rdata = '0;
    logic [N-1:0]      pin_cs;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] exp_grant = '0;
    int exp_ptr = 0;

    always #10 clk = ~clk;

    rrps_pin_sharer u_rrps_pin_sharer (
        .clk(clk), .rst_n(rst_n), .ctl_req(ctl_req), .ctl_grant(ctl_grant),
        .ctl_addr(ctl_addr), .ctl_rd(ctl_rd), .ctl_wr(ctl_wr),
        .ctl_wdata(ctl_wdata), .ctl_wdata_oe(ctl_wdata_oe), .ctl_rdata(ctl_rdata),
        .ctl_cs(ctl_cs), .pin_addr(pin_addr), .pin_rd(pin_rd), .pin_wr(pin_wr),
        .pin_wdata(pin_wdata), .pin_wdata_oe(pin_wdata_oe), .pin_rdata(pin_rdata),
        .pin_cs(pin_cs)
    );

    function automatic logic [31:0] low_mask(input int w);
        return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // grant model built from R1..R4, R6
    task automatic model_step(input logic [N-1:0] r);
        logic found;
        if ((exp_grant & r) == '0) begin
            exp_grant = '0;
            found = 1'b0;
            for (int k = 0; k < N; k++) begin
                int c;
                c = (exp_ptr + k) % N;
                if (!found && r[c]) begin
                    found = 1'b1;
                    exp_grant = N'(1) << c;
                    exp_ptr = (c + 1) % N;
                end
            end
        end
    endtask

    task automatic check_outputs(input string tag);
        int owner;
        logic [31:0] ea, ed;
        owner = -1;
        for (int i = 0; i < N; i++) if (exp_grant[i]) owner = i;
        chk(tag, "grant", 32'(ctl_grant), 32'(exp_grant));
        chk("R5", "grant_count", 32'($countones(ctl_grant)), (32'($countones(ctl_grant)) <= 1) ? 32'($countones(ctl_grant)) : 32'd1);
        if (owner >= 0) begin
            ea = 32'(ctl_addr[owner*AW +: AW]) & low_mask(BAW[owner]);
            ed = 32'(ctl_wdata[owner*DW +: DW]) & low_mask(BDW[owner]);
            chk("R8", "pin_addr", 32'(pin_addr), ea);
            chk("R8", "pin_wdata", 32'(pin_wdata), ed);
            chk("R8", "pin_rd_wr_oe", {29'd0, pin_rd, pin_wr, pin_wdata_oe},
                {29'd0, ctl_rd[owner], ctl_wr[owner], ctl_wdata_oe[owner]});
        end else begin
            chk("R9", "idle_pins", {16'd0, 12'(pin_addr ^ 12'd0), 1'b0, pin_rd, pin_wr, pin_wdata_oe}, 32'd0);
            chk("R9", "idle_wdata", 32'(pin_wdata), 32'd0);
        end
        chk("R10", "pin_cs", 32'(pin_cs), 32'(ctl_cs));
        for (int i = 0; i < N; i++)
            chk("R11", "ctl_rdata", 32'(ctl_rdata[i*DW +: DW]), 32'(pin_rdata));
    endtask

    task automatic drive_random_data();
        ctl_addr     = TOT_AW'({$urandom(), $urandom()});
        ctl_wdata    = TOT_DW'({$urandom(), $urandom()});
        ctl_rd       = N'($urandom());
        ctl_wr       = N'($urandom());
        ctl_wdata_oe = N'($urandom());
        ctl_cs       = N'($urandom());
        pin_rdata    = DW'($urandom());
    endtask

    task automatic cyc(input logic [N-1:0] r, input string tag);
        @(negedge clk);
        ctl_req = r;
        drive_random_data();
        #1;
        check_outputs(tag);
        @(posedge clk);
        model_step(r);
    endtask

    initial begin
        logic [N-1:0] r;
        void'($urandom(32'd2024));
        // reset phase: requests and enables high, nothing may be granted
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            ctl_req = '1;
            drive_random_data();
            ctl_wdata_oe = '1;
            #1;
            chk("R12", "grant_in_reset", 32'(ctl_grant), 32'd0);
            chk("R12", "oe_in_reset", 32'(pin_wdata_oe), 32'd0);
        end
        @(negedge clk);
        ctl_req = '0;
        rst_n = 1'b1;
        exp_grant = '0;
        exp_ptr = 0;
        @(posedge clk);

        repeat (3) cyc(3'b000, "R6");
        cyc(3'b010, "R2");              // grant still low this cycle
        cyc(3'b010, "R2");              // grant 010
        cyc(3'b010, "R3");
        cyc(3'b000, "R4");              // drop: grant still 010
        cyc(3'b010, "R7");              // released, request again
        cyc(3'b010, "R7");              // grant returns
        cyc(3'b111, "R3");              // others wait, owner holds
        cyc(3'b101, "R4");              // owner drops, 0 and 2 pending
        cyc(3'b001, "R1");              // handover to 2 (after 1)
        cyc(3'b000, "R1");              // 2 dropped, wraps to 0
        cyc(3'b000, "R4");
        cyc(3'b000, "R6");

        // random phase, requesters follow the handshake
        r = '0;
        for (int n = 0; n < 3000; n++) begin
            for (int i = 0; i < N; i++) begin
                if (exp_grant[i]) r[i] = ($urandom_range(3) != 0);
                else if (!r[i])   r[i] = ($urandom_range(2) == 0);
            end
            cyc(r, "R1");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule